// File: doc/BRIEF.md
# Priority Peripheral-Bus Arbiter with Lock Tracking

This block sits between several bus masters and several peripheral slaves. A master posts a request with a one-cycle strobe. The request carries a priority, a start address, a read/write flag, a burst length and a lock flag. The arbiter keeps one request slot per master. Whenever the bus is free, or a burst beat has just finished, it picks a winner. It decodes the winner's current address into a one-hot slave select and presents the same transfer every cycle until the selected slave raises its ready line. All state is updated on the falling clock edge.

Bursts advance the word address by one per beat. Between beats, an unlocked burst can be taken over by a request of strictly higher priority. The interrupted burst later resumes where it stopped. Each slot keeps a three-state lock field. A request that asks for the lock takes ownership only if it wins its first arbitration round. While it holds ownership, its burst cannot be interrupted. When a locked transfer that held ownership completes, the lock stays with that master. The master's next locked request of the same priority then wins over other requests of equal priority. Addresses that fall outside every slave window complete at once with an error flag.

Top module: `pbus_arbiter`

## Requirements
- R1: During and right after reset, no master is granted, no slave is selected, no slot is busy, and every lock field reads 0 (none).
- R2: Slave s owns the window whose address bits [AW-1:9] equal s, for s < NS. With the defaults, addresses from 0x800 upward hit no window. In the first cycle after such a request is granted, no select is raised, and ack, done and err are all high. For a hit, the read data is the selected slave's data.
- R3: While the selected slave holds ready low, the same select and address stay on the bus, and the master sees no ack.
- R4: A request with length field L makes L+1 beats at consecutive addresses, one ack per beat. Done is raised only with the last ack.
- R5: The highest priority value wins. Among equal priorities, the lowest master index wins.
- R6: Between beats, an unlocked burst is taken over by a strictly higher priority request, and it resumes at its next address afterwards. A waiting request of equal priority does not take it over.
- R7: A locked request that wins its first round reads lock field 2 (granted) while it runs. Its burst is not taken over by higher priorities. After it completes, the field reads 1 (set).
- R8: A master holds the lock after its granted locked transfer completes. If it posts another locked request of the same priority, that request wins over equal-priority requests from lower indices and reads 2. This includes a request posted in the cycle of the final ack.
- R9: A locked request that loses its first round reads 1 while it waits and while it runs. After it completes, it reads 0.
- R10: The completion of any transfer that did not hold the lock releases the held lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; state changes on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_post | input | NM | Per-master one-cycle request strobe |
| req_prio | input | NM*PW | Per-master priority, larger wins |
| req_addr | input | NM*AW | Per-master start word address |
| req_write | input | NM | Per-master write flag |
| req_len | input | NM*LW | Per-master beats minus one |
| req_lock | input | NM | Per-master lock request |
| req_wdata | input | NM*DW | Per-master write data, passed live to the bus |
| mst_busy | output | NM | Slot holds an unfinished request |
| mst_grant | output | NM | One-hot current bus owner |
| mst_ack | output | NM | Beat completes at the coming falling edge |
| mst_done | output | NM | Last beat completes at the coming falling edge |
| mst_err | output | 1 | Current transfer hits no slave window |
| mst_rdata | output | DW | Read data from the selected slave |
| mst_lock_st | output | NM*2 | Per-slot lock field: 0 none, 1 set, 2 granted |
| slv_sel | output | NS | One-hot slave select |
| slv_addr | output | AW | Current word address |
| slv_write | output | 1 | Current transfer is a write |
| slv_wdata | output | DW | Write data of the owner |
| slv_ready | input | NS | Per-slave transfer completion |
| slv_rdata | input | NS*DW | Per-slave read data |

## Verification
The bench walks the edges of every address window and the region above them. A decoder off by one bit would select the wrong slave or miss the error completion. It holds ready low for several cycles, which exposes a design that advances or drops the request early. A mid-burst higher-priority arrival and an equal-priority arrival separate correct takeover from a design that either never interrupts or interrupts on ties. The lock sequences cover three cases: a back-to-back locked repost in the final-ack cycle, a locked request that loses its first round, and release by an unlocked completion. These catch designs that never grant ownership, never drop it, or take it without winning the first round.

// File: rtl/pbus_arbiter.sv
module pbus_arbiter #(
  parameter int NM   = 3,
  parameter int NS   = 4,
  parameter int AW   = 12,
  parameter int DW   = 16,
  parameter int PW   = 2,
  parameter int LW   = 4,
  parameter int WINB = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NM-1:0]    req_post,
  input  logic [NM*PW-1:0] req_prio,
  input  logic [NM*AW-1:0] req_addr,
  input  logic [NM-1:0]    req_write,
  input  logic [NM*LW-1:0] req_len,
  input  logic [NM-1:0]    req_lock,
  input  logic [NM*DW-1:0] req_wdata,
  output logic [NM-1:0]    mst_busy,
  output logic [NM-1:0]    mst_grant,
  output logic [NM-1:0]    mst_ack,
  output logic [NM-1:0]    mst_done,
  output logic             mst_err,
  output logic [DW-1:0]    mst_rdata,
  output logic [NM*2-1:0]  mst_lock_st,
  output logic [NS-1:0]    slv_sel,
  output logic [AW-1:0]    slv_addr,
  output logic             slv_write,
  output logic [DW-1:0]    slv_wdata,
  input  logic [NS-1:0]    slv_ready,
  input  logic [NS*DW-1:0] slv_rdata
);
  localparam int IW  = AW - WINB;
  localparam int MIW = (NM > 1) ? $clog2(NM) : 1;
  localparam int KW  = PW + 2;

  typedef enum logic [1:0] {LK_NO = 2'd0, LK_SET = 2'd1, LK_GR = 2'd2} lk_t;

  logic [NM-1:0]  act, wr, lkok;
  logic [PW-1:0]  prio [NM];
  logic [AW-1:0]  addr [NM];
  logic [LW-1:0]  left [NM];
  lk_t            lk   [NM];
  logic           cur_v, lh;
  logic [MIW-1:0] cur, lh_m;
  logic [PW-1:0]  lh_p;

  logic [IW-1:0]  sidx;
  logic           hit, miss, fin, last, arb;
  logic           lh_e;
  logic [MIW-1:0] lhm_e, win;
  logic [PW-1:0]  lhp_e;
  logic           win_v;
  logic [NM-1:0]  take, c_act, c_lk, c_ok;
  logic [PW-1:0]  c_p [NM];
  logic [KW-1:0]  key, wkey;

  assign slv_addr = addr[cur];
  assign sidx     = slv_addr[AW-1:WINB];
  assign hit      = {1'b0, sidx} < (IW+1)'(NS);
  assign miss     = cur_v && !hit;
  assign fin      = cur_v && (miss || |(slv_sel & slv_ready));
  assign last     = left[cur] == '0;
  assign arb      = !cur_v || (fin && (last || lk[cur] != LK_GR));
  assign mst_err  = miss;
  assign mst_busy = act;
  assign mst_ack  = fin ? mst_grant : '0;
  assign mst_done = last ? mst_ack : '0;

  for (genvar s = 0; s < NS; s++) begin : g_sel
    assign slv_sel[s] = cur_v && hit && (sidx == IW'(s));
  end

  for (genvar m = 0; m < NM; m++) begin : g_mst
    assign mst_grant[m]         = cur_v && (cur == MIW'(m));
    assign mst_lock_st[m*2 +: 2] = lk[m];
  end

  always_comb begin
    mst_rdata = '0;
    for (int s = 0; s < NS; s++)
      if (slv_sel[s]) mst_rdata = slv_rdata[s*DW +: DW];
    slv_wdata = '0;
    slv_write = 1'b0;
    for (int m = 0; m < NM; m++)
      if (mst_grant[m]) begin
        slv_wdata = req_wdata[m*DW +: DW];
        slv_write = wr[m];
      end
  end

  always_comb begin
    lh_e  = (fin && last) ? (lk[cur] == LK_GR) : lh;
    lhm_e = (fin && last) ? cur : lh_m;
    lhp_e = (fin && last) ? prio[cur] : lh_p;
    win_v = 1'b0;
    win   = '0;
    wkey  = '0;
    for (int m = 0; m < NM; m++) begin
      take[m] = req_post[m] && (!act[m] || (fin && last && cur == MIW'(m)));
      if (take[m]) begin
        c_act[m] = 1'b1;
        c_p[m]   = req_prio[m*PW +: PW];
        c_lk[m]  = req_lock[m];
        c_ok[m]  = req_lock[m];
      end else begin
        c_act[m] = act[m] && !(fin && last && cur == MIW'(m));
        c_p[m]   = prio[m];
        c_lk[m]  = lk[m] != LK_NO;
        c_ok[m]  = lkok[m];
      end
      key = {c_p[m],
             cur_v && cur == MIW'(m) && !take[m],
             lh_e && lhm_e == MIW'(m) && c_lk[m] && c_p[m] == lhp_e};
      if (c_act[m] && (!win_v || key > wkey)) begin
        win_v = 1'b1;
        win   = MIW'(m);
        wkey  = key;
      end
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act   <= '0;
      wr    <= '0;
      lkok  <= '0;
      cur_v <= 1'b0;
      cur   <= '0;
      lh    <= 1'b0;
      lh_m  <= '0;
      lh_p  <= '0;
      for (int m = 0; m < NM; m++) begin
        prio[m] <= '0;
        addr[m] <= '0;
        left[m] <= '0;
        lk[m]   <= LK_NO;
      end
    end else begin
      if (fin) begin
        if (!last) begin
          left[cur] <= left[cur] - 1'b1;
          addr[cur] <= addr[cur] + 1'b1;
        end else begin
          act[cur] <= 1'b0;
          lk[cur]  <= (lk[cur] == LK_GR) ? LK_SET : LK_NO;
          lh       <= lk[cur] == LK_GR;
          lh_m     <= cur;
          lh_p     <= prio[cur];
        end
      end
      for (int m = 0; m < NM; m++)
        if (take[m]) begin
          act[m]  <= 1'b1;
          prio[m] <= req_prio[m*PW +: PW];
          addr[m] <= req_addr[m*AW +: AW];
          wr[m]   <= req_write[m];
          left[m] <= req_len[m*LW +: LW];
          lk[m]   <= req_lock[m] ? LK_SET : LK_NO;
          lkok[m] <= req_lock[m];
        end
      if (arb) begin
        cur_v <= win_v;
        if (win_v) cur <= win;
        for (int m = 0; m < NM; m++)
          if (c_act[m]) begin
            if (win_v && win == MIW'(m))
              lk[m] <= c_lk[m] ? (c_ok[m] ? LK_GR : LK_SET) : LK_NO;
            else
              lkok[m] <= 1'b0;
          end
      end
    end
  end
endmodule

// File: rtl/pbus_arbiter_chk.sv
module pbus_arbiter_chk #(
  parameter int NM = 3,
  parameter int NS = 4,
  parameter int AW = 12
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NM-1:0]   mst_grant,
  input logic [NM-1:0]   mst_ack,
  input logic [NM-1:0]   mst_done,
  input logic [NM-1:0]   mst_busy,
  input logic            mst_err,
  input logic [NM*2-1:0] mst_lock_st,
  input logic [NS-1:0]   slv_sel,
  input logic [AW-1:0]   slv_addr,
  input logic [NS-1:0]   slv_ready
);
  logic [NM-1:0] gmask;
  for (genvar m = 0; m < NM; m++) begin : g_m
    assign gmask[m] = mst_lock_st[m*2 +: 2] == 2'd2;
  end

  p_sel_onehot_r2: assert property (@(negedge clk) disable iff (!rst_n)
    $onehot0(slv_sel));

  p_miss_err_r2: assert property (@(negedge clk) disable iff (!rst_n)
    (|mst_grant && !(|slv_sel)) |-> (mst_err && |mst_ack && |mst_done));

  p_hold_wait_r3: assert property (@(negedge clk) disable iff (!rst_n)
    (|slv_sel && !(|(slv_sel & slv_ready))) |=> ($stable(slv_sel) && $stable(slv_addr)));

  p_grant_onehot_r5: assert property (@(negedge clk) disable iff (!rst_n)
    $onehot0(mst_grant));

  p_grant_busy_r5: assert property (@(negedge clk) disable iff (!rst_n)
    (mst_grant & ~mst_busy) == '0);

  p_lock_keep_r7: assert property (@(negedge clk) disable iff (!rst_n)
    (|mst_ack && !(|mst_done) && |(mst_grant & gmask)) |=> $stable(mst_grant));
endmodule

bind pbus_arbiter pbus_arbiter_chk #(.NM(NM), .NS(NS), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mst_grant(mst_grant), .mst_ack(mst_ack),
  .mst_done(mst_done), .mst_busy(mst_busy), .mst_err(mst_err),
  .mst_lock_st(mst_lock_st), .slv_sel(slv_sel), .slv_addr(slv_addr),
  .slv_ready(slv_ready)
);

// File: tb/test_pbus_arbiter.sv
`timescale 1ns/1ps
module test_pbus_arbiter;
  localparam int NM = 3, NS = 4, AW = 12, DW = 16, PW = 2, LW = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [NM-1:0]    req_post = '0, req_write = '0, req_lock = '0;
  logic [NM*PW-1:0] req_prio = '0;
  logic [NM*AW-1:0] req_addr = '0;
  logic [NM*LW-1:0] req_len = '0;
  logic [NM*DW-1:0] req_wdata = '0;
  logic [NM-1:0]    mst_busy, mst_grant, mst_ack, mst_done;
  logic             mst_err, slv_write;
  logic [DW-1:0]    mst_rdata, slv_wdata;
  logic [NM*2-1:0]  mst_lock_st;
  logic [NS-1:0]    slv_sel;
  logic [AW-1:0]    slv_addr;
  logic [NS-1:0]    slv_ready = '1;
  logic [NS*DW-1:0] slv_rdata;
  int checks = 0, errors = 0;

  assign slv_rdata = {16'hA003, 16'hA002, 16'hA001, 16'hA000};

  always #10 clk = ~clk;

  pbus_arbiter #(.NM(NM), .NS(NS), .AW(AW), .DW(DW), .PW(PW), .LW(LW)) i_pbus_arbiter (
    .clk(clk), .rst_n(rst_n), .req_post(req_post), .req_prio(req_prio),
    .req_addr(req_addr), .req_write(req_write), .req_len(req_len),
    .req_lock(req_lock), .req_wdata(req_wdata), .mst_busy(mst_busy),
    .mst_grant(mst_grant), .mst_ack(mst_ack), .mst_done(mst_done),
    .mst_err(mst_err), .mst_rdata(mst_rdata), .mst_lock_st(mst_lock_st),
    .slv_sel(slv_sel), .slv_addr(slv_addr), .slv_write(slv_write),
    .slv_wdata(slv_wdata), .slv_ready(slv_ready), .slv_rdata(slv_rdata)
  );

  // {address, expected select, expected error}
  localparam logic [16:0] VEC [7] = '{
    {12'h000, 4'b0001, 1'b0},
    {12'h1FF, 4'b0001, 1'b0},
    {12'h200, 4'b0010, 1'b0},
    {12'h5A5, 4'b0100, 1'b0},
    {12'h7FF, 4'b1000, 1'b0},
    {12'h800, 4'b0000, 1'b1},
    {12'hFFF, 4'b0000, 1'b1}
  };

  task automatic check(string tag, logic [31:0] a, logic [31:0] e);
    checks++;
    if (a !== e) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, a, e);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #2;
    req_post = '0;
  endtask

  task automatic post(int m, int p, int a, int len, bit lk);
    req_post[m]            = 1'b1;
    req_prio[m*PW +: PW]   = p[PW-1:0];
    req_addr[m*AW +: AW]   = a[AW-1:0];
    req_len[m*LW +: LW]    = len[LW-1:0];
    req_lock[m]            = lk;
    req_write[m]           = 1'b0;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    #3;
    check("R1 grant in reset", 32'(mst_grant), 0);
    check("R1 select in reset", 32'(slv_sel), 0);
    check("R1 busy in reset", 32'(mst_busy), 0);
    check("R1 lock fields in reset", 32'(mst_lock_st), 0);
    rst_n = 1'b1;
    step(); #1;
    check("R1 grant after reset", 32'(mst_grant), 0);

    for (int i = 0; i < 7; i++) begin
      step();
      post(0, 0, int'(VEC[i][16:5]), 0, 1'b0);
      step(); #1;
      check("R2 select", 32'(slv_sel), 32'(VEC[i][4:1]));
      check("R2 error flag", 32'(mst_err), 32'(VEC[i][0]));
      check("R2 done", 32'(mst_done), 32'b001);
      check("R2 read data", 32'(mst_rdata),
            VEC[i][0] ? 32'h0 : 32'hA000 + 32'(VEC[i][16:14]));
    end

    step();
    post(1, 0, 'h210, 0, 1'b0);
    slv_ready = '0;
    step(); #1;
    check("R3 select while waiting", 32'(slv_sel), 32'b0010);
    check("R3 no ack while waiting", 32'(mst_ack), 0);
    step(); #1;
    check("R3 select held", 32'(slv_sel), 32'b0010);
    check("R3 address held", 32'(slv_addr), 32'h210);
    check("R3 still no ack", 32'(mst_ack), 0);
    step();
    slv_ready = '1;
    #1;
    check("R3 ack on ready", 32'(mst_ack), 32'b010);

    step();
    slv_ready = '0;
    post(0, 1, 'h000, 0, 1'b0);
    post(1, 2, 'h200, 0, 1'b0);
    post(2, 2, 'h400, 0, 1'b0);
    step(); #1;
    check("R5 highest priority, lowest index", 32'(mst_grant), 32'b010);
    slv_ready = '1;
    step(); #1;
    check("R5 second winner", 32'(mst_grant), 32'b100);
    step(); #1;
    check("R5 lowest priority last", 32'(mst_grant), 32'b001);

    step();
    post(2, 1, 'h100, 3, 1'b0);
    step(); #1;
    check("R4 burst first grant", 32'(mst_grant), 32'b100);
    check("R4 first address", 32'(slv_addr), 32'h100);
    check("R4 no done on first beat", 32'(mst_done), 0);
    step(); #1;
    check("R4 second address", 32'(slv_addr), 32'h101);
    post(0, 3, 'h300, 0, 1'b0);
    step(); #1;
    check("R6 higher priority takes over", 32'(mst_grant), 32'b001);
    check("R6 takeover select", 32'(slv_sel), 32'b0010);
    step(); #1;
    check("R6 burst resumes", 32'(mst_grant), 32'b100);
    check("R6 resume address", 32'(slv_addr), 32'h102);
    step(); #1;
    check("R4 last address", 32'(slv_addr), 32'h103);
    check("R4 done on last beat", 32'(mst_done), 32'b100);

    step();
    post(2, 1, 'h000, 1, 1'b0);
    step(); #1;
    check("R6 equal burst granted", 32'(mst_grant), 32'b100);
    post(0, 1, 'h200, 0, 1'b0);
    step(); #1;
    check("R6 equal priority no takeover", 32'(mst_grant), 32'b100);
    check("R6 equal burst last beat", 32'(mst_done), 32'b100);
    step(); #1;
    check("R6 waiter served after", 32'(mst_grant), 32'b001);

    step();
    post(1, 1, 'h000, 1, 1'b1);
    step(); #1;
    check("R7 locked grant", 32'(mst_grant), 32'b010);
    check("R7 lock field granted", 32'(mst_lock_st[3:2]), 2);
    post(0, 2, 'h200, 0, 1'b0);
    step(); #1;
    check("R7 locked burst kept", 32'(mst_grant), 32'b010);
    check("R7 locked burst address", 32'(slv_addr), 32'h001);
    step(); #1;
    check("R7 higher after lock", 32'(mst_grant), 32'b001);
    check("R7 lock field back to set", 32'(mst_lock_st[3:2]), 1);

    step();
    post(1, 1, 'h000, 0, 1'b1);
    step(); #1;
    check("R8 first locked grant", 32'(mst_lock_st[3:2]), 2);
    post(0, 1, 'h200, 0, 1'b0);
    post(1, 1, 'h201, 0, 1'b1);
    step(); #1;
    check("R8 lock holder wins tie", 32'(mst_grant), 32'b010);
    check("R8 repost granted", 32'(mst_lock_st[3:2]), 2);
    check("R8 repost address", 32'(slv_addr), 32'h201);
    step(); #1;
    check("R8 waiter served", 32'(mst_grant), 32'b001);
    step();
    post(0, 1, 'h000, 0, 1'b0);
    post(1, 1, 'h200, 0, 1'b1);
    step(); #1;
    check("R10 lock released, index wins", 32'(mst_grant), 32'b001);
    check("R9 loser field set", 32'(mst_lock_st[3:2]), 1);
    step(); #1;
    check("R9 loser granted", 32'(mst_grant), 32'b010);
    check("R9 loser not granted lock", 32'(mst_lock_st[3:2]), 1);
    step(); #1;
    check("R9 field none after", 32'(mst_lock_st[3:2]), 0);
    check("R9 bus idle", 32'(mst_grant), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule